// File: doc/BRIEF.md
# DMA Halt/Resume Control and Status Register

This block is the single host-visible control/status word for a network controller's two DMA engines, one for receive and one for transmit. The host writes the word to issue halt and resume commands. These command bits act once and are never stored. The block turns each accepted command into a one-cycle request pulse toward the matching engine. While any halt is waiting for its engine to report that it has stopped, the block raises a shared busy indication.

Reading the word returns several other pieces of state. It shows a latched per-channel "frame DMA finished" flag, which mirrors the interrupt-status bit for that channel and clears only through that bit's acknowledge strobe. It shows a live view of whether a transmit DMA transfer is active. It also holds a read/write bit that selects the tick period of the companion countdown timer. Software is expected to halt the transmit engine before polling the transmit-active bit, for example during underrun recovery.

Channel 0 is receive and channel 1 is transmit on every per-channel vector port.

Top module: `dmactl_halt_reg`

## Requirements
- R1: After synchronous reset, `reg_rdata` reads 0 (with `tx_dma_busy` low), no request pulse is driven and `rate_fast` is 0.
- R2: A write with bit 8 / 9 / 10 / 11 set drives `halt_req[0]` / `resume_req[0]` / `halt_req[1]` / `resume_req[1]` high for exactly the one cycle after the write, once per write.
- R3: Command bits written as 0 cause no request pulse, and bits 8..11 always read back as 0.
- R4: Bit 15 (halt busy) reads 1 from the cycle after a halt write until every channel with a pending halt has seen its `halted_ack` high; a still-pending channel keeps it at 1.
- R5: `frame_done[0]` / `frame_done[1]` sets read bit 3 / bit 4 from the next cycle, and the bit stays set until `done_ack` for that channel is high.
- R6: When `frame_done` and `done_ack` of one channel are high in the same cycle, that channel's flag is 1 afterwards.
- R7: Read bit 14 follows the `tx_dma_busy` input in the same cycle.
- R8: Bit 18 is read/write and drives `rate_fast`. A value of 1 selects the 320 ns tick and 0 selects the 3.2 us tick. It is updated on every write.
- R9: Bits 0..2, 5..7, 12, 13, 16, 17 and 19..31 read as 0. Writes to them, and to the read-only bits 3, 4, 14 and 15, have no effect.
- R10: A resume command never sets halt busy.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Current register read value |
| frame_done | input | 2 | Per-channel frame DMA finished event |
| done_ack | input | 2 | Per-channel interrupt-status acknowledge |
| halt_req | output | 2 | Per-channel one-cycle halt request |
| resume_req | output | 2 | Per-channel one-cycle resume request |
| halted_ack | input | 2 | Per-channel engine reports it has halted |
| tx_dma_busy | input | 1 | Transmit DMA transfer active |
| rate_fast | output | 1 | Countdown tick select, 1 = 320 ns |

## Verification
On every cycle the assertions check several properties. Each request pulse must trace back to a write with its command bit set. Busy must rise after a halt write and must not drop while no halted acknowledge arrives. Completion flags must set after an event and hold until acknowledged. Reserved bits must read zero, and the rate bit must follow the last write. Only the bench's scenarios show the full command sweep: the exact pulse mapping for all sixteen command combinations, the staggered release of busy as the two engines acknowledge one after the other, the event-versus-acknowledge collision, and the reset values.

// File: rtl/dmactl_pkg.sv
package dmactl_pkg;

    localparam int REG_W         = 32;
    localparam int NUM_CH        = 2;
    localparam int CMD_BASE      = 8;   // halt at CMD_BASE+2*ch, resume one above
    localparam int DONE_BASE     = 3;   // done flag at DONE_BASE+ch
    localparam int BIT_TX_ACTIVE = 14;
    localparam int BIT_HALT_BUSY = 15;
    localparam int BIT_RATE      = 18;

    typedef enum logic [0:0] {
        CH_RX = 1'b0,
        CH_TX = 1'b1
    } dma_ch_e;

    typedef struct packed {
        logic              rate_fast;
        logic              halt_busy;
        logic              tx_active;
        logic [NUM_CH-1:0] done;
    } stat_view_t;

    function automatic int halt_bit(input int ch);
        return CMD_BASE + 2 * ch;
    endfunction

    function automatic int resume_bit(input int ch);
        return CMD_BASE + 2 * ch + 1;
    endfunction

    function automatic int done_bit(input int ch);
        return DONE_BASE + ch;
    endfunction

    function automatic logic [REG_W-1:0] pack_read(input stat_view_t s);
        logic [REG_W-1:0] w;
        w = '0;
        for (int c = 0; c < NUM_CH; c++) begin
            w[done_bit(c)] = s.done[c];
        end
        w[BIT_TX_ACTIVE] = s.tx_active;
        w[BIT_HALT_BUSY] = s.halt_busy;
        w[BIT_RATE]      = s.rate_fast;
        return w;
    endfunction

    function automatic logic [REG_W-1:0] readable_mask();
        stat_view_t all;
        all = '1;
        return pack_read(all);
    endfunction

endpackage

// File: rtl/dmactl_cmd_pulse.sv
module dmactl_cmd_pulse
    import dmactl_pkg::*;
#(
    parameter int W  = REG_W,
    parameter int NC = NUM_CH
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          wr,
    input  logic [W-1:0]  wdata,
    output logic [NC-1:0] halt_hit,
    output logic [NC-1:0] halt_pulse,
    output logic [NC-1:0] resume_pulse
);
    for (genvar c = 0; c < NC; c++) begin : g_ch
        logic resume_hit;
        always_comb begin
            halt_hit[c] = wr && wdata[CMD_BASE + 2*c];
            resume_hit  = wr && wdata[CMD_BASE + 2*c + 1];
        end
        always_ff @(posedge clk) begin
            if (rst) begin
                halt_pulse[c]   <= 1'b0;
                resume_pulse[c] <= 1'b0;
            end else begin
                halt_pulse[c]   <= halt_hit[c];
                resume_pulse[c] <= resume_hit;
            end
        end
    end
endmodule

// File: rtl/dmactl_halt_track.sv
module dmactl_halt_track (
    input  logic clk,
    input  logic rst,
    input  logic accept,
    input  logic halted,
    output logic pending
);
    always_ff @(posedge clk) begin
        if (rst)         pending <= 1'b0;
        else if (accept) pending <= 1'b1;
        else if (halted) pending <= 1'b0;
    end
endmodule

// File: rtl/dmactl_done_latch.sv
module dmactl_done_latch (
    input  logic clk,
    input  logic rst,
    input  logic event_in,
    input  logic ack,
    output logic flag
);
    always_ff @(posedge clk) begin
        if (rst) flag <= 1'b0;
        else     flag <= event_in | (flag & ~ack);
    end
endmodule

// File: rtl/dmactl_halt_reg.sv
module dmactl_halt_reg
    import dmactl_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              reg_wr,
    input  logic [REG_W-1:0]  reg_wdata,
    output logic [REG_W-1:0]  reg_rdata,
    input  logic [NUM_CH-1:0] frame_done,
    input  logic [NUM_CH-1:0] done_ack,
    output logic [NUM_CH-1:0] halt_req,
    output logic [NUM_CH-1:0] resume_req,
    input  logic [NUM_CH-1:0] halted_ack,
    input  logic              tx_dma_busy,
    output logic              rate_fast
);
    logic [NUM_CH-1:0] halt_hit;
    logic [NUM_CH-1:0] pend;
    logic [NUM_CH-1:0] done_q;
    logic              rate_q;
    stat_view_t        view;

    dmactl_cmd_pulse #(.W(REG_W), .NC(NUM_CH)) u_cmd (
        .clk          (clk),
        .rst          (rst),
        .wr           (reg_wr),
        .wdata        (reg_wdata),
        .halt_hit     (halt_hit),
        .halt_pulse   (halt_req),
        .resume_pulse (resume_req)
    );

    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
        dmactl_halt_track u_trk (
            .clk     (clk),
            .rst     (rst),
            .accept  (halt_hit[c]),
            .halted  (halted_ack[c]),
            .pending (pend[c])
        );
        dmactl_done_latch u_done (
            .clk      (clk),
            .rst      (rst),
            .event_in (frame_done[c]),
            .ack      (done_ack[c]),
            .flag     (done_q[c])
        );
    end

    always_ff @(posedge clk) begin
        if (rst)         rate_q <= 1'b0;
        else if (reg_wr) rate_q <= reg_wdata[BIT_RATE];
    end

    always_comb begin
        view.done      = done_q;
        view.tx_active = tx_dma_busy;
        view.halt_busy = |pend;
        view.rate_fast = rate_q;
        reg_rdata      = pack_read(view);
        rate_fast      = rate_q;
    end
endmodule

// File: rtl/dmactl_halt_reg_chk.sv
module dmactl_halt_reg_chk
    import dmactl_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              reg_wr,
    input logic [REG_W-1:0]  reg_wdata,
    input logic [REG_W-1:0]  reg_rdata,
    input logic [NUM_CH-1:0] frame_done,
    input logic [NUM_CH-1:0] done_ack,
    input logic [NUM_CH-1:0] halt_req,
    input logic [NUM_CH-1:0] resume_req,
    input logic [NUM_CH-1:0] halted_ack,
    input logic              rate_fast
);
    localparam logic [REG_W-1:0] RD_MASK = readable_mask();

    assert_rx_halt_src_R2: assert property (@(posedge clk) disable iff (rst)
        halt_req[0] |-> $past(reg_wr && reg_wdata[8]));
    assert_tx_halt_src_R2: assert property (@(posedge clk) disable iff (rst)
        halt_req[1] |-> $past(reg_wr && reg_wdata[10]));
    assert_rx_resume_src_R3: assert property (@(posedge clk) disable iff (rst)
        resume_req[0] |-> $past(reg_wr && reg_wdata[9]));
    assert_tx_resume_src_R3: assert property (@(posedge clk) disable iff (rst)
        resume_req[1] |-> $past(reg_wr && reg_wdata[11]));
    assert_busy_set_R4: assert property (@(posedge clk) disable iff (rst)
        (reg_wr && (reg_wdata[8] || reg_wdata[10])) |=> reg_rdata[15]);
    assert_busy_hold_R4: assert property (@(posedge clk) disable iff (rst)
        (reg_rdata[15] && halted_ack == '0) |=> reg_rdata[15]);
    assert_rx_done_set_R5: assert property (@(posedge clk) disable iff (rst)
        frame_done[0] |=> reg_rdata[3]);
    assert_tx_done_set_R6: assert property (@(posedge clk) disable iff (rst)
        frame_done[1] |=> reg_rdata[4]);
    assert_rx_done_hold_R5: assert property (@(posedge clk) disable iff (rst)
        (reg_rdata[3] && !done_ack[0]) |=> reg_rdata[3]);
    assert_rate_follow_R8: assert property (@(posedge clk) disable iff (rst)
        reg_wr |=> (rate_fast == $past(reg_wdata[18])));
    assert_rsvd_zero_R9: assert property (@(posedge clk) disable iff (rst)
        (reg_rdata & ~RD_MASK) == '0);
    assert_resume_no_busy_R10: assert property (@(posedge clk) disable iff (rst)
        (!reg_rdata[15] && !(reg_wr && (reg_wdata[8] || reg_wdata[10]))) |=> !reg_rdata[15]);
endmodule

bind dmactl_halt_reg dmactl_halt_reg_chk u_chk (.*);

// File: tb/dmactl_halt_reg_test.sv
module dmactl_halt_reg_test;
    logic        clk = 1'b0;
    logic        rst;
    logic        reg_wr;
    logic [31:0] reg_wdata;
    logic [31:0] reg_rdata;
    logic [1:0]  frame_done, done_ack, halt_req, resume_req, halted_ack;
    logic        tx_dma_busy, rate_fast;

    int n_chk = 0;
    int n_bad = 0;
    bit finished = 0;

    always #2 clk = ~clk;   // 250 MHz

    dmactl_halt_reg uut (
        .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .frame_done(frame_done), .done_ack(done_ack),
        .halt_req(halt_req), .resume_req(resume_req), .halted_ack(halted_ack),
        .tx_dma_busy(tx_dma_busy), .rate_fast(rate_fast)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] exp_word(input logic [1:0] dn, input logic txa,
                                             input logic busy, input logic rate);
        logic [31:0] w;
        w = '0;
        w[3] = dn[0]; w[4] = dn[1]; w[14] = txa; w[15] = busy; w[18] = rate;
        return w;
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog actual=%h expected=%h", 32'd0, 32'd1);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        rst = 1'b1; reg_wr = 0; reg_wdata = '0; frame_done = 0; done_ack = 0;
        halted_ack = 0; tx_dma_busy = 0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk("R1 rdata", reg_rdata, 32'h0);
        chk("R1 req", {28'd0, halt_req, resume_req}, 32'h0);
        chk("R1 rate", {31'd0, rate_fast}, 32'h0);

        // Sweep all command combinations, with junk in reserved/read-only bits
        for (int cmd = 0; cmd < 16; cmd++) begin
            logic rate;
            logic txa;
            logic [1:0] hexp;
            rate = cmd[1] ^ cmd[3];
            txa  = cmd[3];
            hexp = {cmd[2], cmd[0]};
            tx_dma_busy = txa;
            reg_wr = 1;
            reg_wdata = 32'hFFFB_F0FF | (32'(cmd) << 8) | (32'(rate) << 18);
            @(negedge clk);
            reg_wr = 0; reg_wdata = '0;
            chk("R2 halt_req", {30'd0, halt_req}, {30'd0, hexp});
            chk("R2 resume_req", {30'd0, resume_req}, {30'd0, cmd[3], cmd[1]});
            chk("R4 R9 R7 R8 R10 rdata", reg_rdata, exp_word(2'b00, txa, |hexp, rate));
            chk("R8 rate_fast", {31'd0, rate_fast}, {31'd0, rate});
            @(negedge clk);
            chk("R2 single pulse", {28'd0, halt_req, resume_req}, 32'h0);
            chk("R4 busy held", {31'd0, reg_rdata[15]}, {31'd0, |hexp});
            halted_ack = {1'b0, hexp[0]};
            @(negedge clk);
            chk("R4 partial ack", {31'd0, reg_rdata[15]}, {31'd0, hexp[1]});
            halted_ack = {hexp[1], 1'b0};
            @(negedge clk);
            halted_ack = 0;
            chk("R4 cleared", {31'd0, reg_rdata[15]}, 32'h0);
        end

        // Zero write: no pulses, rate cleared
        reg_wr = 1; reg_wdata = '0;
        @(negedge clk);
        reg_wr = 0;
        chk("R3 zero write", {28'd0, halt_req, resume_req}, 32'h0);
        chk("R3 R8 rdata", reg_rdata, exp_word(2'b00, tx_dma_busy, 1'b0, 1'b0));
        tx_dma_busy = 0;

        // Completion flags
        frame_done = 2'b01;
        @(negedge clk);
        frame_done = 0;
        chk("R5 rx set", reg_rdata, exp_word(2'b01, 0, 0, 0));
        repeat (3) @(negedge clk);
        chk("R5 rx hold", reg_rdata, exp_word(2'b01, 0, 0, 0));
        frame_done = 2'b10;
        @(negedge clk);
        frame_done = 0;
        chk("R5 both set", reg_rdata, exp_word(2'b11, 0, 0, 0));
        done_ack = 2'b01;
        @(negedge clk);
        done_ack = 0;
        chk("R5 rx ack", reg_rdata, exp_word(2'b10, 0, 0, 0));
        frame_done = 2'b10; done_ack = 2'b10;
        @(negedge clk);
        frame_done = 0; done_ack = 0;
        chk("R6 collide set flag", reg_rdata, exp_word(2'b10, 0, 0, 0));
        frame_done = 2'b01; done_ack = 2'b01;
        @(negedge clk);
        frame_done = 0; done_ack = 0;
        chk("R6 collide clear flag", reg_rdata, exp_word(2'b11, 0, 0, 0));
        done_ack = 2'b11;
        @(negedge clk);
        done_ack = 0;
        chk("R5 both ack", reg_rdata, exp_word(2'b00, 0, 0, 0));

        // Read-only bits cannot be written
        reg_wr = 1; reg_wdata = 32'h0004_C018;
        @(negedge clk);
        reg_wr = 0; reg_wdata = '0;
        chk("R9 ro bits", reg_rdata, exp_word(2'b00, 0, 0, 1));
        tx_dma_busy = 1;
        #1;
        chk("R7 live", {31'd0, reg_rdata[14]}, 32'h1);

        // Reset mid-state
        reg_wr = 1; reg_wdata = 32'h0000_0500;
        @(negedge clk);
        reg_wr = 0; tx_dma_busy = 0; frame_done = 2'b11; rst = 1;
        @(negedge clk);
        frame_done = 0; rst = 0;
        @(negedge clk);
        chk("R1 reset clears", reg_rdata, 32'h0);
        chk("R1 reset pulses", {28'd0, halt_req, resume_req}, 32'h0);

        finished = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule